// File: doc/BRIEF.md
# Card Bus Clock Generator

This block makes the card bus clock from the controller's input clock. Two stages set the rate and work one after the other. The first is a prescaler. It passes the input clock straight through when its field is zero; otherwise it divides by twice its field value. The second is an integer divider that divides the prescaler output by its field value plus one. The card clock comes from a registered flop, so it never glitches. Each card period starts with its low phase.

Software controls the block through two write ports:

- **Rate word:** a 16-bit write that sets the prescaler and divider fields.
- **Command write:** a 4-bit write with stop, start and soft-reset bits.

A new rate takes effect only at a period boundary, so the card never sees a runt pulse. A stop request lets the current period finish and then parks the clock low. A running flag shows whether the clock is active. A soft reset stops the clock at once, clears the counters and restores the default rate. It also sends a one-cycle pulse to the rest of the controller.

Top module: `cardclk_gen`

## Requirements
- R1: The rate word holds the prescaler in bits [15:4] and the divider in bits [3:0]. One card period lasts (div+1)×P input cycles, where P is 1 when the prescaler field is 0 and 2×prescaler otherwise.
- R2: Within a period the card clock is low for ceil((div+1)/2)×P cycles and then high for floor((div+1)/2)×P cycles.
- R3: A divider field of 0 acts as a divider of 1.
- R4: The fastest setting (prescaler 0, divider 1) gives the input divided by 2. The prescaler reaches 0x800, so prescaler 0x800 with divider 1 gives 8192 input cycles per period, and divider 15 gives input/65536.
- R5: In a command write, bit 0 requests stop, bit 1 requests start and bit 3 requests soft reset. Bit 2 has no effect. When several bits are set together, soft reset wins over stop, and stop wins over start.
- R6: A start from the stopped state reloads the counters and the rate word. The first card clock rising edge is seen ceil((div+1)/2)×P+1 input cycles after the edge that samples the start write.
- R7: A stop while running lets the current period complete, including its full high phase. After that the card clock stays low and the running flag falls at the period end.
- R8: A start while a stop is still pending cancels the stop, and the clock keeps running without a break.
- R9: A rate write while running leaves the current period unchanged. The new rate applies from the next period's low phase.
- R10: clkRunning is high from the edge that samples a start until the clock stops.
- R11: A soft reset clears clkRunning on the same edge that samples it. The card clock is low one cycle later. softRstPulse is high for exactly one cycle. The rate word returns to RESET_RATE (default 0x0003, which divides by 4 with a 2-cycle high phase).
- R12: After a hardware reset, cardClk, clkRunning and softRstPulse are all low and the rate word equals RESET_RATE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller input clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rateWrEn | input | 1 | Rate word write strobe |
| rateData | input | 16 | Rate word: prescaler [15:4], divider [3:0] |
| ctrlWrEn | input | 1 | Command write strobe |
| ctrlData | input | 4 | Command bits: 0 stop, 1 start, 3 soft reset |
| cardClk | output | 1 | Card bus clock |
| clkRunning | output | 1 | Card clock active flag |
| softRstPulse | output | 1 | One-cycle pulse issued on soft reset |

## Verification
The bench builds the block with its default parameters: a 12-bit prescaler field, a 4-bit divider field and a reset rate of 0x0003. With these values the bench can exercise the bypassed prescaler, mid-range prescaler values including one that is not a power of two, the zero divider, and the 0x800 prescaler edge, each within a short run. Period and high-phase lengths are measured between observed card clock edges. The start latency, the stop boundary, a mid-period rate change and the soft reset are each timed in exact input cycles.

// File: rtl/cardclk_pkg.sv
`timescale 1ns/1ps
package cardclk_pkg;

  // Command bit positions in the control write (behavioural encoding)
  localparam int CTRL_W         = 4;
  localparam int CTRL_STOP_BIT  = 0;
  localparam int CTRL_START_BIT = 1;
  localparam int CTRL_RESET_BIT = 3;

  // Decoded command strobes
  typedef struct packed {
    logic reset;
    logic stop;
    logic start;
  } clkCmd_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;     // counters advance
    logic reload;  // clear counters and capture rate word
  } dpCtl_t;

endpackage

// File: rtl/cardclk_dp.sv
`timescale 1ns/1ps
module cardclk_dp
  import cardclk_pkg::*;
#(
  parameter int PRE_W = 12,
  parameter int DIV_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpCtl_t                 ctl,
  input  logic [PRE_W+DIV_W-1:0] rateWord,
  output logic                   cardClk,
  output logic                   periodEnd
);
  localparam int RATE_W = PRE_W + DIV_W;
  localparam int CNT_W  = PRE_W + 1;
  localparam int LEN_W  = DIV_W + 1;

  logic [PRE_W-1:0] actPre;
  logic [DIV_W-1:0] actDiv;
  logic [DIV_W-1:0] divEff;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] preCnt;
  logic [CNT_W-1:0] preLimit;
  logic [LEN_W-1:0] lowLen;
  logic             tick;
  logic             cardClkQ;

  // Divider of zero behaves as one
  always_comb divEff = (actDiv == '0) ? DIV_W'(1) : actDiv;

  // Prescaler: bypass at zero, else count 2*pre input cycles per tick
  always_comb preLimit = (actPre == '0) ? '0 : ({actPre, 1'b0} - CNT_W'(1));

  // Low phase covers the first ceil((div+1)/2) ticks of each period
  always_comb lowLen = ({1'b0, divEff} + LEN_W'(2)) >> 1;

  always_comb begin
    tick      = ctl.run && (preCnt == preLimit);
    periodEnd = tick && (divCnt == divEff);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      divCnt <= '0;
      actPre <= '0;
      actDiv <= '0;
    end else if (ctl.reload) begin
      preCnt <= '0;
      divCnt <= '0;
      actPre <= rateWord[RATE_W-1:DIV_W];
      actDiv <= rateWord[DIV_W-1:0];
    end else if (ctl.run) begin
      preCnt <= tick ? '0 : preCnt + CNT_W'(1);
      if (tick) begin
        divCnt <= periodEnd ? '0 : divCnt + DIV_W'(1);
      end
      if (periodEnd) begin
        // new rate only at a period boundary: no runt pulse
        actPre <= rateWord[RATE_W-1:DIV_W];
        actDiv <= rateWord[DIV_W-1:0];
      end
    end
  end

  // Registered output: glitch free
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cardClkQ <= 1'b0;
    else       cardClkQ <= ctl.run && ({1'b0, divCnt} >= lowLen);
  end

  assign cardClk = cardClkQ;

  // R2: with the counters idle the card clock is held low
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.run) |-> !cardClk);

  // R1: divider count never passes the effective divider
  a_r1_div_range: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |-> (divCnt <= divEff));

  // R1: prescaler count never passes its limit
  a_r1_pre_range: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |-> (preCnt <= preLimit));

  // R9: active rate changes only at a boundary or a reload
  a_r9_rate_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && !ctl.reload && !periodEnd) |=> ($stable(actPre) && $stable(actDiv)));

endmodule

// File: rtl/cardclk_ctrl.sv
`timescale 1ns/1ps
module cardclk_ctrl
  import cardclk_pkg::*;
#(
  parameter int                RATE_W     = 16,
  parameter logic [RATE_W-1:0] RESET_RATE = 16'h0003
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlData,
  input  logic              rateWrEn,
  input  logic [RATE_W-1:0] rateData,
  input  logic              periodEnd,
  output dpCtl_t            dpCtl,
  output logic [RATE_W-1:0] rateWord,
  output logic              running,
  output logic              rstPulse
);
  clkCmd_t          cmd;
  logic             stopPend;
  logic             runNext;
  logic             pendNext;
  logic             freshStart;
  logic [RATE_W-1:0] rateReg;

  always_comb begin
    cmd.reset = ctrlWrEn && ctrlData[CTRL_RESET_BIT];
    cmd.stop  = ctrlWrEn && ctrlData[CTRL_STOP_BIT];
    cmd.start = ctrlWrEn && ctrlData[CTRL_START_BIT];
  end

  // Next-state: reset > stop > start; a pending stop ends at the boundary
  always_comb begin
    runNext    = running;
    pendNext   = stopPend;
    freshStart = 1'b0;
    if (periodEnd && stopPend) begin
      runNext  = 1'b0;
      pendNext = 1'b0;
    end
    if (cmd.reset) begin
      runNext  = 1'b0;
      pendNext = 1'b0;
    end else if (cmd.stop) begin
      pendNext = runNext;
    end else if (cmd.start) begin
      if (!runNext) begin
        runNext    = 1'b1;
        freshStart = 1'b1;
      end
      pendNext = 1'b0;
    end
  end

  always_comb begin
    dpCtl.run    = running;
    dpCtl.reload = cmd.reset || freshStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      stopPend <= 1'b0;
      rstPulse <= 1'b0;
      rateReg  <= RESET_RATE;
    end else begin
      running  <= runNext;
      stopPend <= pendNext;
      rstPulse <= cmd.reset;
      if (cmd.reset)     rateReg <= RESET_RATE;
      else if (rateWrEn) rateReg <= rateData;
    end
  end

  assign rateWord = rateReg;

  // R7: a pending stop exists only while the clock runs
  a_r7_pend_running: assert property (@(posedge clk) disable iff (!rstN)
    stopPend |-> running);

  // R7: the clock stops only at a period end or on soft reset
  a_r7_fall_boundary: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> ($past(periodEnd) || $past(cmd.reset)));

  // R11: reset pulse follows a reset command and the clock is off
  a_r11_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |-> (!running && $past(cmd.reset)));

  // R6: a lone start from stopped sets the running state
  a_r6_start_runs: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.start && !cmd.stop && !cmd.reset && !running) |=> running);

endmodule

// File: rtl/cardclk_gen.sv
`timescale 1ns/1ps
module cardclk_gen
  import cardclk_pkg::*;
#(
  parameter int PRE_W = 12,
  parameter int DIV_W = 4,
  parameter logic [PRE_W+DIV_W-1:0] RESET_RATE = 16'h0003
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rateWrEn,
  input  logic [PRE_W+DIV_W-1:0] rateData,
  input  logic                   ctrlWrEn,
  input  logic [CTRL_W-1:0]      ctrlData,
  output logic                   cardClk,
  output logic                   clkRunning,
  output logic                   softRstPulse
);
  localparam int RATE_W = PRE_W + DIV_W;

  dpCtl_t            dpCtl;
  logic [RATE_W-1:0] rateWord;
  logic              periodEnd;

  cardclk_ctrl #(
    .RATE_W    (RATE_W),
    .RESET_RATE(RESET_RATE)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWrEn (ctrlWrEn),
    .ctrlData (ctrlData),
    .rateWrEn (rateWrEn),
    .rateData (rateData),
    .periodEnd(periodEnd),
    .dpCtl    (dpCtl),
    .rateWord (rateWord),
    .running  (clkRunning),
    .rstPulse (softRstPulse)
  );

  cardclk_dp #(
    .PRE_W(PRE_W),
    .DIV_W(DIV_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (dpCtl),
    .rateWord (rateWord),
    .cardClk  (cardClk),
    .periodEnd(periodEnd)
  );

endmodule

// File: tb/cardclk_gen_test.sv
`timescale 1ns/1ps
module cardclk_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rateWrEn = 1'b0;
  logic [15:0] rateData = '0;
  logic        ctrlWrEn = 1'b0;
  logic [3:0]  ctrlData = '0;
  logic        cardClk;
  logic        clkRunning;
  logic        softRstPulse;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  cardclk_gen uut (
    .clk(clk), .rstN(rstN), .rateWrEn(rateWrEn), .rateData(rateData),
    .ctrlWrEn(ctrlWrEn), .ctrlData(ctrlData), .cardClk(cardClk),
    .clkRunning(clkRunning), .softRstPulse(softRstPulse)
  );

  // {rate word, expected period, expected high cycles}
  localparam int NVEC = 10;
  localparam logic [47:0] VEC [NVEC] = '{
    {16'h0001, 16'd2,    16'd1},     // R4 fastest: input/2
    {16'h000F, 16'd16,   16'd8},
    {16'h0000, 16'd2,    16'd1},     // R3 divider 0 acts as 1
    {16'h0011, 16'd4,    16'd2},
    {16'h0022, 16'd12,   16'd4},
    {16'h0043, 16'd32,   16'd16},
    {16'h0104, 16'd160,  16'd64},
    {16'h8001, 16'd8192, 16'd4096},  // R4 prescaler 0x800
    {16'h0007, 16'd8,    16'd4},
    {16'h0035, 16'd36,   16'd18}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrRate(input logic [15:0] v);
    @(negedge clk); rateWrEn = 1'b1; rateData = v;
    @(negedge clk); rateWrEn = 1'b0;
  endtask

  task automatic wrCtrl(input logic [3:0] v);
    @(negedge clk); ctrlWrEn = 1'b1; ctrlData = v;
    @(negedge clk); ctrlWrEn = 1'b0; ctrlData = '0;
  endtask

  task automatic measure(output int per, output int hi);
    int lo;
    while (cardClk)  @(negedge clk);
    while (!cardClk) @(negedge clk);
    hi = 0;
    while (cardClk) begin @(negedge clk); hi++; end
    lo = 0;
    while (!cardClk) begin @(negedge clk); lo++; end
    per = hi + lo;
  endtask

  task automatic cyclesToRise(output int n);
    n = 0;
    while (!cardClk) begin @(negedge clk); n++; end
  endtask

  task automatic highsOver(input int len, output int n);
    n = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (cardClk) n++;
    end
  endtask

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    finishRun();
  end

  initial begin
    int per, hi, n;
    repeat (5) @(negedge clk);
    // R12 reset state
    chk("R12 cardClk after reset", int'(cardClk), 0);
    chk("R12 clkRunning after reset", int'(clkRunning), 0);
    chk("R12 softRstPulse after reset", int'(softRstPulse), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 cardClk idle", int'(cardClk), 0);

    // R6/R10 start with default rate (R12 reset value 0x0003)
    wrCtrl(4'b0010);
    chk("R10 running after start", int'(clkRunning), 1);
    cyclesToRise(n);
    chk("R6 first rise latency", n, 3);
    measure(per, hi);
    chk("R12 reset rate period", per, 4);
    chk("R12 reset rate high", hi, 2);

    // R1/R2 table walk
    for (int i = 0; i < NVEC; i++) begin
      wrRate(VEC[i][47:32]);
      measure(per, hi);
      measure(per, hi);
      chk($sformatf("R1 period rate %h", VEC[i][47:32]), per, int'(VEC[i][31:16]));
      chk($sformatf("R2 high rate %h", VEC[i][47:32]), hi, int'(VEC[i][15:0]));
    end

    // R9 rate change during a high phase
    wrRate(16'h000F);
    measure(per, hi);
    measure(per, hi);
    while (cardClk)  @(negedge clk);
    while (!cardClk) @(negedge clk);
    n = 0;
    rateData = 16'h0001;
    while (cardClk) begin
      rateWrEn = (n == 3);
      @(negedge clk);
      n++;
    end
    rateWrEn = 1'b0;
    chk("R9 current high kept", n, 8);
    n = 0;
    while (!cardClk) begin @(negedge clk); n++; end
    chk("R9 new low phase", n, 1);
    n = 0;
    while (cardClk) begin @(negedge clk); n++; end
    chk("R9 new high phase", n, 1);

    // R7 stop finishes the period
    wrRate(16'h000F);
    measure(per, hi);
    measure(per, hi);
    while (!cardClk) @(negedge clk);
    while (cardClk)  @(negedge clk);
    wrCtrl(4'b0001);
    chk("R10 running while stop pending", int'(clkRunning), 1);
    cyclesToRise(n);
    n = 0;
    while (cardClk) begin @(negedge clk); n++; end
    chk("R7 last high complete", n, 8);
    chk("R7 running low at period end", int'(clkRunning), 0);
    highsOver(64, n);
    chk("R7 held low after stop", n, 0);

    // R6 restart from stopped
    wrCtrl(4'b0010);
    cyclesToRise(n);
    chk("R6 restart latency", n, 9);

    // R8 start cancels pending stop
    while (cardClk) @(negedge clk);
    wrCtrl(4'b0001);
    wrCtrl(4'b0010);
    measure(per, hi);
    measure(per, hi);
    chk("R8 period after cancel", per, 16);
    chk("R8 still running", int'(clkRunning), 1);

    // R5 stop wins over start
    wrCtrl(4'b0011);
    repeat (40) @(negedge clk);
    chk("R5 stop over start", int'(clkRunning), 0);
    // R5 bit 2 has no effect
    wrCtrl(4'b0100);
    highsOver(20, n);
    chk("R5 bit2 ignored running", int'(clkRunning), 0);
    chk("R5 bit2 ignored clock", n, 0);

    // R11 soft reset while running
    wrCtrl(4'b0010);
    wrRate(16'h0022);
    measure(per, hi);
    measure(per, hi);
    wrCtrl(4'b1000);
    chk("R11 pulse high", int'(softRstPulse), 1);
    chk("R11 running cleared", int'(clkRunning), 0);
    @(negedge clk);
    chk("R11 pulse one cycle", int'(softRstPulse), 0);
    chk("R11 clock low", int'(cardClk), 0);
    highsOver(30, n);
    chk("R11 held low", n, 0);
    wrCtrl(4'b0010);
    cyclesToRise(n);
    chk("R11 reset rate latency", n, 3);
    measure(per, hi);
    chk("R11 reset rate period", per, 4);
    chk("R11 reset rate high", hi, 2);

    // R5 reset wins over start
    wrCtrl(4'b1010);
    chk("R5 reset over start", int'(clkRunning), 0);
    highsOver(10, n);
    chk("R5 reset over start clock", n, 0);

    finishRun();
  end
endmodule